// File: doc/BRIEF.md
# IPV-Programmed Re-Reference Replacement Engine

This block holds the replacement metadata for a 4-way set-associative cache. Each resident line has a 2-bit re-reference prediction (RRPV) and a valid bit. A low RRPV means the line is expected to be used again soon. A high RRPV means it is expected to be evicted unused. Tags, data, miss handling and the memory side belong to other blocks. This engine only updates the predictions and names the way to overwrite when a line is brought in.

Promotion and insertion follow two programmable five-entry vectors: one for demand traffic and one for prefetch traffic. Entries 0 to 3 give the new RRPV of a hit line, indexed by its current RRPV. Entry 4 gives the RRPV of a freshly filled line. When no way in the set can be evicted, all ways are aged in one step. Both vectors reset to a general-purpose pair and can be rewritten through a small configuration port.

Requests enter on a valid/ready stream. The engine takes one request at a time. `req_ready` is high only while it is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each accepted request produces exactly one response. The response stays on `resp_valid` with stable fields until a clock edge sees `resp_ready` high. No new request is taken while a response is waiting.

Top module: `rrpv_repl_engine`

## Requirements
- R1: After reset every way of every set is invalid, `req_ready` is 1 and `resp_valid` is 0. The first fills to a set return ways 0, 1, 2, 3 in that order with `resp_evicted`=0.
- R2: A fill into a set that has an invalid way takes the lowest-numbered invalid way. It reports `resp_evicted`=0 and leaves the RRPVs of the other ways unchanged (no aging).
- R3: In a fully valid set, a fill evicts only a way whose RRPV is 3, and picks the lowest-numbered one when several are at 3. It reports `resp_evicted`=1.
- R4: When a fully valid set has no way at RRPV 3, every way is raised by the same amount (3 minus the largest RRPV in the set) before the victim is picked. The result is the same as repeating single increments of all ways.
- R5: A hit on a valid way sets its RRPV to the vector entry selected by its current RRPV. The vector is a 10-bit word in which entry k occupies bits [2k+1:2k]. Entries 0 to 3 are the hit targets for RRPV 0 to 3.
- R6: A filled way gets the RRPV held in bits [9:8] of the applicable vector, whatever value the previous occupant of that way had.
- R7: `req_prefetch`=1 selects the prefetch vector for both the hit update and the fill. `req_prefetch`=0 selects the demand vector.
- R8: After reset the demand vector is entries (0,1,1,0,3) for k=0..4, and the prefetch vector is (0,1,0,0,3).
- R9: A cycle with `cfg_wr_en`=1 replaces the demand vector (`cfg_wr_prefetch`=0) or the prefetch vector (`cfg_wr_prefetch`=1) with `cfg_wr_vec`. Any vector can be loaded, including the data-heavy pair: demand (0,0,0,1,3) and prefetch (0,0,1,1,3).
- R10: A request with both `req_hit` and `req_fill` set applies the hit update to `req_way` first. The victim is then chosen from the updated set.
- R11: A hit naming an invalid way has no effect on the set.
- R12: `req_ready` and `resp_valid` are never high together, and `req_ready` drops after an accepted request. `resp_way`, `resp_filled` and `resp_evicted` hold steady while the response waits. `resp_filled` equals the request's `req_fill`, and `resp_evicted` is 1 only on a fill that displaced a valid line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_set | input | SET_W | Set index |
| req_prefetch | input | 1 | 1 = prefetch access, 0 = demand access |
| req_hit | input | 1 | Access hit in `req_way` |
| req_way | input | WAY_W | Way that hit |
| req_fill | input | 1 | A new line must be placed in this set |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_way | output | WAY_W | Victim way on a fill, otherwise the request way |
| resp_filled | output | 1 | Response belongs to a fill |
| resp_evicted | output | 1 | The victim held a valid line |
| cfg_wr_en | input | 1 | Write a vector this cycle |
| cfg_wr_prefetch | input | 1 | 1 = prefetch vector, 0 = demand vector |
| cfg_wr_vec | input | 10 | New vector, entry k at bits [2k+1:2k] |

## Verification
Short directed sequences separate the corner cases. Fills into an empty set show the invalid-first order. Fills into a set whose ways are all at 3 show the lowest-index tie-break and the reset insertion value. Sets whose ways were all promoted to 0 or 1 expose the one-step aging. A combined hit-and-fill request on a full set distinguishes hit-first ordering, because a fill done first would pick a different way. Long pseudo-random streams over four sets then mix demand and prefetch hits, hits on invalid ways and fills under the default pair, the data-heavy pair and arbitrary vectors. Any wrong promotion entry appears as a victim differing from an independent model that ages by repeated single increments. Random stalls on `resp_ready` check that responses are held.

// File: rtl/rrpv_pkg.sv
package rrpv_pkg;

  localparam int RRPV_W = 2;
  localparam int VEC_W  = 5 * RRPV_W;

  typedef logic [RRPV_W-1:0] rrpv_t;
  typedef logic [VEC_W-1:0]  ipv_t;

  localparam rrpv_t RRPV_TOP = rrpv_t'(3);

  // entry k at bits [2k+1:2k]; entry 4 is the insertion value
  localparam ipv_t DEMAND_RESET   = {2'd3, 2'd0, 2'd1, 2'd1, 2'd0};
  localparam ipv_t PREFETCH_RESET = {2'd3, 2'd0, 2'd0, 2'd1, 2'd0};

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIT  = 2'd1,
    ST_FILL = 2'd2,
    ST_RESP = 2'd3
  } eng_state_e;

  function automatic rrpv_t ipv_promote(input ipv_t vec, input rrpv_t cur);
    return vec[int'(cur)*RRPV_W +: RRPV_W];
  endfunction

  function automatic rrpv_t ipv_insert(input ipv_t vec);
    return vec[4*RRPV_W +: RRPV_W];
  endfunction

endpackage

// File: rtl/rrpv_ipv_regs.sv
module rrpv_ipv_regs
  import rrpv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_prefetch,
  input  ipv_t wr_vec,
  output ipv_t demand_vec,
  output ipv_t prefetch_vec
);

  localparam int NUM_VEC = 2;

  ipv_t vec_q [NUM_VEC];

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    localparam ipv_t INIT = (g == 0) ? DEMAND_RESET : PREFETCH_RESET;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q[g] <= INIT;
      end else if (wr_en && (int'(wr_prefetch) == g)) begin
        vec_q[g] <= wr_vec;
      end
    end
  end

  assign demand_vec   = vec_q[0];
  assign prefetch_vec = vec_q[1];

endmodule

// File: rtl/rrpv_meta_store.sv
module rrpv_meta_store
  import rrpv_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int WAYS     = 4,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SET_W-1:0]        rd_set,
  output logic [WAYS-1:0][RRPV_W-1:0] rd_rrpv,
  output logic [WAYS-1:0]         rd_valid,
  input  logic                    wr_en,
  input  logic [SET_W-1:0]        wr_set,
  input  logic [WAYS-1:0][RRPV_W-1:0] wr_rrpv,
  input  logic [WAYS-1:0]         wr_valid
);

  logic [WAYS-1:0][RRPV_W-1:0] rrpv_q  [NUM_SETS];
  logic [WAYS-1:0]             valid_q [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rrpv_q[s]  <= '0;
        valid_q[s] <= '0;
      end else if (wr_en && (int'(wr_set) == s)) begin
        rrpv_q[s]  <= wr_rrpv;
        valid_q[s] <= wr_valid;
      end
    end
  end

  always_comb begin
    rd_rrpv  = '0;
    rd_valid = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (int'(rd_set) == s) begin
        rd_rrpv  = rrpv_q[s];
        rd_valid = valid_q[s];
      end
    end
  end

endmodule

// File: rtl/rrpv_victim_sel.sv
module rrpv_victim_sel
  import rrpv_pkg::*;
#(
  parameter int WAYS   = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][RRPV_W-1:0] rrpv_in,
  input  logic [WAYS-1:0]             valid_in,
  output logic [WAY_W-1:0]            victim,
  output logic                        victim_was_valid,
  output logic [WAYS-1:0][RRPV_W-1:0] rrpv_aged
);

  logic       set_full;
  rrpv_t      peak;
  rrpv_t      lift;
  logic [WAY_W-1:0] first_free;
  logic [WAY_W-1:0] first_peak;

  assign set_full = &valid_in;

  always_comb begin
    peak = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rrpv_in[w] > peak) peak = rrpv_in[w];
    end
    lift = RRPV_TOP - peak;
  end

  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    first_free = '0;
    first_peak = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_in[w])       first_free = WAY_W'(w);
      if (rrpv_in[w] == peak) first_peak = WAY_W'(w);
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_age
    assign rrpv_aged[g] = set_full ? rrpv_t'(rrpv_in[g] + lift) : rrpv_in[g];
  end

  assign victim           = set_full ? first_peak : first_free;
  assign victim_was_valid = set_full;

endmodule

// File: rtl/rrpv_repl_engine.sv
module rrpv_repl_engine
  import rrpv_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int WAYS     = 4,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SET_W-1:0] req_set,
  input  logic             req_prefetch,
  input  logic             req_hit,
  input  logic [WAY_W-1:0] req_way,
  input  logic             req_fill,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [WAY_W-1:0] resp_way,
  output logic             resp_filled,
  output logic             resp_evicted,
  input  logic             cfg_wr_en,
  input  logic             cfg_wr_prefetch,
  input  logic [9:0]       cfg_wr_vec
);

  eng_state_e state_q;

  logic [SET_W-1:0] set_q;
  logic             pf_q;
  logic             hit_q;
  logic [WAY_W-1:0] way_q;
  logic             fill_q;

  logic [WAY_W-1:0] resp_way_q;
  logic             resp_filled_q;
  logic             resp_evicted_q;

  ipv_t demand_vec;
  ipv_t prefetch_vec;
  ipv_t active_vec;

  logic [WAYS-1:0][RRPV_W-1:0] rd_rrpv;
  logic [WAYS-1:0]             rd_valid;
  logic [WAYS-1:0][RRPV_W-1:0] wr_rrpv;
  logic [WAYS-1:0]             wr_valid;
  logic                        wr_en;

  logic [WAYS-1:0][RRPV_W-1:0] aged_rrpv;
  logic [WAY_W-1:0]            victim;
  logic                        victim_was_valid;

  rrpv_ipv_regs u_vecs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_wr_en),
    .wr_prefetch  (cfg_wr_prefetch),
    .wr_vec       (cfg_wr_vec),
    .demand_vec   (demand_vec),
    .prefetch_vec (prefetch_vec)
  );

  rrpv_meta_store #(
    .NUM_SETS (NUM_SETS),
    .WAYS     (WAYS)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (set_q),
    .rd_rrpv  (rd_rrpv),
    .rd_valid (rd_valid),
    .wr_en    (wr_en),
    .wr_set   (set_q),
    .wr_rrpv  (wr_rrpv),
    .wr_valid (wr_valid)
  );

  rrpv_victim_sel #(
    .WAYS (WAYS)
  ) u_victim (
    .rrpv_in          (rd_rrpv),
    .valid_in         (rd_valid),
    .victim           (victim),
    .victim_was_valid (victim_was_valid),
    .rrpv_aged        (aged_rrpv)
  );

  assign active_vec = pf_q ? prefetch_vec : demand_vec;

  // metadata update: hit step, then fill step, on separate cycles
  always_comb begin
    wr_en    = 1'b0;
    wr_rrpv  = rd_rrpv;
    wr_valid = rd_valid;
    case (state_q)
      ST_HIT: begin
        if (hit_q && rd_valid[way_q]) begin
          wr_en          = 1'b1;
          wr_rrpv[way_q] = ipv_promote(active_vec, rd_rrpv[way_q]);
        end
      end
      ST_FILL: begin
        wr_en            = 1'b1;
        wr_rrpv          = aged_rrpv;
        wr_rrpv[victim]  = ipv_insert(active_vec);
        wr_valid[victim] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      set_q          <= '0;
      pf_q           <= 1'b0;
      hit_q          <= 1'b0;
      way_q          <= '0;
      fill_q         <= 1'b0;
      resp_way_q     <= '0;
      resp_filled_q  <= 1'b0;
      resp_evicted_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            set_q   <= req_set;
            pf_q    <= req_prefetch;
            hit_q   <= req_hit;
            way_q   <= req_way;
            fill_q  <= req_fill;
            state_q <= ST_HIT;
          end
        end
        ST_HIT: begin
          if (fill_q) begin
            state_q <= ST_FILL;
          end else begin
            resp_way_q     <= way_q;
            resp_filled_q  <= 1'b0;
            resp_evicted_q <= 1'b0;
            state_q        <= ST_RESP;
          end
        end
        ST_FILL: begin
          resp_way_q     <= victim;
          resp_filled_q  <= 1'b1;
          resp_evicted_q <= victim_was_valid;
          state_q        <= ST_RESP;
        end
        ST_RESP: begin
          if (resp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign resp_valid   = (state_q == ST_RESP);
  assign resp_way     = resp_way_q;
  assign resp_filled  = resp_filled_q;
  assign resp_evicted = resp_evicted_q;

endmodule

// File: rtl/rrpv_repl_engine_chk.sv
module rrpv_repl_engine_chk #(
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_fill,
  input logic             resp_valid,
  input logic             resp_ready,
  input logic [WAY_W-1:0] resp_way,
  input logic             resp_filled,
  input logic             resp_evicted
);

  logic fill_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_taken <= 1'b0;
    else if (req_valid && req_ready) fill_taken <= req_fill;
  end

  // R12
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R12
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && resp_valid));

  // R12
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=>
      (resp_valid && $stable(resp_way) && $stable(resp_filled) && $stable(resp_evicted)));

  // R12
  fill_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_filled == fill_taken));

  // R2
  evict_needs_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_evicted |-> resp_filled);

endmodule

bind rrpv_repl_engine rrpv_repl_engine_chk #(.WAY_W(WAY_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_fill     (req_fill),
  .resp_valid   (resp_valid),
  .resp_ready   (resp_ready),
  .resp_way     (resp_way),
  .resp_filled  (resp_filled),
  .resp_evicted (resp_evicted)
);

// File: tb/rrpv_repl_engine_bench.sv
module rrpv_repl_engine_bench;

  localparam int NS    = 4;
  localparam int NW    = 4;
  localparam int SET_W = 2;
  localparam int WAY_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [SET_W-1:0] req_set = '0;
  logic req_prefetch = 1'b0;
  logic req_hit = 1'b0;
  logic [WAY_W-1:0] req_way = '0;
  logic req_fill = 1'b0;
  logic resp_valid;
  logic resp_ready = 1'b0;
  logic [WAY_W-1:0] resp_way;
  logic resp_filled;
  logic resp_evicted;
  logic cfg_wr_en = 1'b0;
  logic cfg_wr_prefetch = 1'b0;
  logic [9:0] cfg_wr_vec = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  int m_rr [NS][NW];
  bit m_v  [NS][NW];
  logic [9:0] m_vec [2];

  always #2 clk = ~clk;

  rrpv_repl_engine #(.NUM_SETS(NS), .WAYS(NW)) u_rrpv_repl_engine (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_set(req_set),
    .req_prefetch(req_prefetch), .req_hit(req_hit), .req_way(req_way),
    .req_fill(req_fill), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_way(resp_way), .resp_filled(resp_filled), .resp_evicted(resp_evicted),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_prefetch(cfg_wr_prefetch), .cfg_wr_vec(cfg_wr_vec)
  );

  function automatic logic [9:0] pack_vec(int a, int b, int c, int d, int e);
    return {e[1:0], d[1:0], c[1:0], b[1:0], a[1:0]};
  endfunction

  function automatic int rnd(int n);
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return int'(lfsr % n);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(bit pf, logic [9:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_prefetch = pf; cfg_wr_vec = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    m_vec[pf] = v;
  endtask

  // one request: model update, drive, compare; tag "" picks R2/R3/R4 by case
  task automatic do_req(int s, bit pf, bit hit, int way, bit fill, string tag);
    int exp_way = way;
    bit exp_ev = 0;
    bit aged = 0;
    bit has_free = 0;
    string lab;
    int got_way;
    bit got_fill, got_ev;
    int hold;
    if (hit && m_v[s][way]) m_rr[s][way] = int'(m_vec[pf][2*m_rr[s][way] +: 2]);
    if (fill) begin
      for (int w = NW - 1; w >= 0; w--) if (!m_v[s][w]) begin has_free = 1; exp_way = w; end
      if (!has_free) begin
        exp_ev = 1;
        exp_way = -1;
        while (exp_way < 0) begin
          for (int w = NW - 1; w >= 0; w--) if (m_rr[s][w] == 3) exp_way = w;
          if (exp_way < 0) begin
            aged = 1;
            for (int w = 0; w < NW; w++) m_rr[s][w]++;
          end
        end
      end
      m_rr[s][exp_way] = int'(m_vec[pf][9:8]);
      m_v[s][exp_way] = 1;
    end
    lab = (tag != "") ? tag : (!fill ? "R12" : (has_free ? "R2" : (aged ? "R4" : "R3")));

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_set = SET_W'(s); req_prefetch = pf;
    req_hit = hit; req_way = WAY_W'(way); req_fill = fill;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    got_way = int'(resp_way); got_fill = resp_filled; got_ev = resp_evicted;
    check(got_fill == fill, "R12", "resp_filled", int'(got_fill), int'(fill));
    if (fill) begin
      check(got_way == exp_way, lab, "victim way", got_way, exp_way);
      check(got_ev == exp_ev, lab, "evicted flag", int'(got_ev), int'(exp_ev));
    end
    hold = rnd(3);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      check(resp_valid && int'(resp_way) == got_way && resp_filled == got_fill,
            "R12", "held response way", int'(resp_way), got_way);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        finished = 1;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) begin m_rr[s][w] = 0; m_v[s][w] = 0; end
    m_vec[0] = pack_vec(0, 1, 1, 0, 3);
    m_vec[1] = pack_vec(0, 1, 0, 0, 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    check(resp_valid == 1'b0, "R1", "resp_valid after reset", int'(resp_valid), 0);

    // R1 / R2: empty set fills ways 0..3
    for (int i = 0; i < NW; i++) do_req(0, 0, 0, 0, 1, "R1");
    // R3, R8: default insert 3, all tie, lowest way taken
    do_req(0, 0, 0, 0, 1, "R3");
    // R8 / R5: demand hit at 3 -> 0, prefetch hit at 3 -> 0
    do_req(0, 0, 1, 1, 0, "R5");
    do_req(0, 1, 1, 2, 0, "R7");
    // R6: way 0 refilled, new value is insert entry regardless of history
    do_req(0, 0, 0, 0, 1, "R6");
    // R10: hit way 0 and fill together: hit first gives way 3
    do_req(0, 0, 1, 0, 1, "R10");
    // R4: all at 0 now except one; promote the rest and force aging
    do_req(0, 0, 1, 3, 0, "R5");
    do_req(0, 0, 0, 0, 1, "R4");
    do_req(0, 0, 0, 0, 1, "R4");

    // R11: hit on invalid way then fills still in order 0..3
    do_req(1, 0, 1, 2, 0, "R11");
    for (int i = 0; i < NW; i++) do_req(1, 0, 0, 0, 1, "R11");

    // R9: data-heavy pair, set 2
    cfg_write(0, pack_vec(0, 0, 0, 1, 3));
    cfg_write(1, pack_vec(0, 0, 1, 1, 3));
    for (int i = 0; i < NW; i++) do_req(2, 0, 0, 0, 1, "R9");
    do_req(2, 0, 1, 1, 0, "R9");
    do_req(2, 1, 1, 0, 0, "R9");
    do_req(2, 0, 0, 0, 1, "R9");
    // R9: insertion value 1 forces aging on next fill
    cfg_write(0, pack_vec(2, 1, 0, 3, 1));
    for (int i = 0; i < NW; i++) do_req(3, 0, 0, 0, 1, "R9");
    do_req(3, 0, 0, 0, 1, "R9");

    // sweeps across vector pairs
    for (int phase = 0; phase < 4; phase++) begin
      if (phase == 0) begin
        cfg_write(0, pack_vec(0, 1, 1, 0, 3));
        cfg_write(1, pack_vec(0, 1, 0, 0, 3));
      end else if (phase == 1) begin
        cfg_write(0, pack_vec(0, 0, 0, 1, 3));
        cfg_write(1, pack_vec(0, 0, 1, 1, 3));
      end
      for (int n = 0; n < 600; n++) begin
        if (phase >= 2 && (n % 150) == 0) begin
          cfg_write(0, 10'(rnd(1024)));
          cfg_write(1, 10'(rnd(1024)));
        end
        begin
          bit h = bit'(rnd(2));
          bit f = bit'(rnd(2));
          do_req(rnd(NS), bit'(rnd(2)), h, rnd(NW), f, "");
        end
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule